// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers transfer-completion events from up to 32 DMA channels into one pending vector and turns them into a single shared completion interrupt for a CPU. Each completion arrives as a one-cycle strobe with a 5-bit code. The code selects the pending bit to set. Early and normal completions both use the same strobe and set bits in the same way.

Software sees the block through a small register port with three locations. It reads the pending vector. It writes and reads an enable mask. It clears pending bits by writing ones to a clear location. The interrupt is a one-cycle pulse gated by an internal armed flag. After a pulse, no further pulse is raised until every enabled pending bit has gone back to zero. This lets a service routine read, handle, clear and read again until the vector is empty. Completions that land in the meantime still show up on reads. Once the enabled pending set is empty the block re-arms, so the next enabled completion produces a fresh pulse.

Register addresses (`reg_addr`, `rd_addr`): 0 = pending (read only; writes are ignored), 1 = enable (read/write), 2 = clear (write-one-to-clear; reads return 0), 3 = reserved (reads return 0, writes ignored).

Top module: `dma_cmpl_irq_agg`

## Requirements
- R1: A strobe on `cmpl_valid` with code n sets pending bit n on the next clock edge, for every n from 0 to 31, whether the completion was early or normal.
- R2: `irq_pulse` is the only interrupt output, shared by all channels, and is never high for two cycles in a row.
- R3: A pending bit whose enable bit (address 1) is 0 never causes `irq_pulse`.
- R4: Writing to address 2 clears each pending bit whose data bit is 1. Bits written as 0 are left unchanged. Reads of address 2 return 0.
- R5: After a pulse, no further pulse is issued while the pending vector ANDed with the enable mask stays nonzero.
- R6: Completions arriving while earlier bits are pending set their bits and are visible on pending reads, without raising a pulse.
- R7: When a completion and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: After reset, pending and enable read as 0, `irq_pulse` is 0, and the block is armed.
- R9: If the masked pending vector is zero in one cycle and an enabled completion arrives in the next cycle, a pulse is issued in the cycle its bit becomes visible.
- R10: Address 0 reads the pending vector and address 1 reads the enable mask. Reads have no side effects, and writes to address 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmpl_valid | input | 1 | Completion strobe, early or normal |
| cmpl_code | input | 5 | Index of the pending bit to set |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register write address |
| reg_wdata | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq_pulse | output | 1 | Shared completion interrupt, one-cycle pulse |

## Verification
On every cycle, the assertions check that a pulse never lasts two cycles, that a pulse always has an enabled pending bit behind it, and that no pulse follows a disarmed cycle with a nonzero masked vector. They also check that a set bit is present after its strobe and that a zero in the clear data never drops a bit. Only the bench scenarios can show the whole service sequence. That sequence covers accumulation of new bits while the interrupt is held, re-arming after a full drain, and the fresh pulse one cycle after the vector empties. The bench also covers the set-beats-clear collision, ignored writes to the pending location, and the read mapping for each address.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    ADDR_PEND  = 2'd0,
    ADDR_EN    = 2'd1,
    ADDR_CLR   = 2'd2,
    ADDR_RSVD  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_agg_rst_sync.sv
module irq_agg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/irq_agg_pend.sv
module irq_agg_pend #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned CODE_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_vld,
  input  logic [CODE_W-1:0] set_code,
  input  logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] pend_q
);
  logic [NUM_CH-1:0] set_mask;
  logic [NUM_CH-1:0] pend_d;
  logic              pend_upd;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign set_mask[i] = set_vld && (set_code == CODE_W'(i));
  end

  // Set takes priority over a simultaneous clear of the same bit (R7)
  always_comb begin
    pend_d   = (pend_q & ~clr_mask) | set_mask;
    pend_upd = set_vld || (|clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= '0;
    else if (pend_upd) pend_q <= pend_d;
  end

  assert_set_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    set_vld |=> ((pend_q & $past(set_mask)) == $past(set_mask)));

  assert_zero_clear_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ($past(pend_q) & ~$past(clr_mask)))
              == ($past(pend_q) & ~$past(clr_mask))));
endmodule

// File: rtl/irq_agg_regif.sv
module irq_agg_regif
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [NUM_CH-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic [NUM_CH-1:0] pend,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] rd_data
);
  logic en_we;

  always_comb begin
    en_we    = wr_en && (reg_addr_e'(wr_addr) == ADDR_EN);
    clr_mask = (wr_en && (reg_addr_e'(wr_addr) == ADDR_CLR)) ? wr_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= wr_data;
  end

  always_comb begin
    unique case (reg_addr_e'(rd_addr))
      ADDR_PEND: rd_data = pend;
      ADDR_EN:   rd_data = en_q;
      default:   rd_data = '0;
    endcase
  end

  assert_en_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == 2'd1)) |=> $stable(en_q));
endmodule

// File: rtl/irq_agg_pulse.sv
module irq_agg_pulse #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] masked,
  output logic              irq
);
  logic armed_q;
  logic armed_d;
  logic any_masked;

  always_comb begin
    any_masked = |masked;
    irq        = armed_q && any_masked;
    if (irq)             armed_d = 1'b0;
    else if (!any_masked) armed_d = 1'b1;
    else                 armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= armed_d;
  end

  assert_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_hold_until_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && any_masked) |=> !irq);
endmodule

// File: rtl/dma_cmpl_irq_agg.sv
module dma_cmpl_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned CODE_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmpl_valid,
  input  logic [CODE_W-1:0] cmpl_code,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [NUM_CH-1:0] reg_wdata,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [NUM_CH-1:0] rd_data,
  output logic              irq_pulse
);
  logic              rst_n_sync;
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] clr_mask;
  logic [NUM_CH-1:0] masked;

  irq_agg_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  irq_agg_pend #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_pend (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .set_vld  (cmpl_valid),
    .set_code (cmpl_code),
    .clr_mask (clr_mask),
    .pend_q   (pend_q)
  );

  irq_agg_regif #(.NUM_CH(NUM_CH)) i_regif (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_en    (reg_wr_en),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata),
    .rd_addr  (rd_addr),
    .pend     (pend_q),
    .en_q     (en_q),
    .clr_mask (clr_mask),
    .rd_data  (rd_data)
  );

  assign masked = pend_q & en_q;

  irq_agg_pulse #(.NUM_CH(NUM_CH)) i_pulse (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .masked (masked),
    .irq    (irq_pulse)
  );

  assert_irq_enabled_only_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    irq_pulse |-> ((pend_q & en_q) != '0));
endmodule

// File: tb/test_dma_cmpl_irq_agg.sv
`timescale 1ns/1ps
module test_dma_cmpl_irq_agg;
  logic        clk;
  logic        rst_n;
  logic        cmpl_valid;
  logic [4:0]  cmpl_code;
  logic        reg_wr_en;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        irq_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dma_cmpl_irq_agg i_dma_cmpl_irq_agg (
    .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_pulse(irq_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        cv;
    logic [4:0]  code;
    logic        we;
    logic [1:0]  wa;
    logic [31:0] wd;
    logic [1:0]  ra;
    logic [31:0] erd;
    logic        eirq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd0,  1'b1, 2'd1, 32'hFFFF_FFFF, 2'd1, 32'hFFFF_FFFF, 1'b0, 4'd10}, // R10 enable write
    '{1'b1, 5'd3,  1'b0, 2'd0, 32'h0,         2'd0, 32'h0000_0008, 1'b1, 4'd1},  // R1 set + pulse
    '{1'b0, 5'd0,  1'b0, 2'd0, 32'h0,         2'd0, 32'h0000_0008, 1'b0, 4'd2},  // R2 single cycle
    '{1'b1, 5'd7,  1'b0, 2'd0, 32'h0,         2'd0, 32'h0000_0088, 1'b0, 4'd6},  // R6 accumulate held
    '{1'b0, 5'd0,  1'b1, 2'd2, 32'h0000_0008, 2'd0, 32'h0000_0080, 1'b0, 4'd5},  // R5 partial clear
    '{1'b0, 5'd0,  1'b1, 2'd2, 32'h0000_0080, 2'd0, 32'h0000_0000, 1'b0, 4'd4},  // R4 drain
    '{1'b1, 5'd31, 1'b0, 2'd0, 32'h0,         2'd0, 32'h8000_0000, 1'b1, 4'd9},  // R9 fresh pulse
    '{1'b1, 5'd31, 1'b1, 2'd2, 32'h8000_0000, 2'd0, 32'h8000_0000, 1'b0, 4'd7},  // R7 set wins
    '{1'b0, 5'd0,  1'b1, 2'd2, 32'h8000_0000, 2'd0, 32'h0000_0000, 1'b0, 4'd4},  // R4 clear
    '{1'b0, 5'd0,  1'b1, 2'd1, 32'h0000_00F0, 2'd1, 32'h0000_00F0, 1'b0, 4'd10}, // R10 enable read
    '{1'b1, 5'd0,  1'b0, 2'd0, 32'h0,         2'd0, 32'h0000_0001, 1'b0, 4'd3},  // R3 disabled bit
    '{1'b0, 5'd0,  1'b0, 2'd0, 32'h0,         2'd2, 32'h0000_0000, 1'b0, 4'd4},  // R4 clear reads 0
    '{1'b1, 5'd4,  1'b0, 2'd0, 32'h0,         2'd0, 32'h0000_0011, 1'b1, 4'd1},  // R1 enabled bit
    '{1'b0, 5'd0,  1'b1, 2'd2, 32'h0000_0000, 2'd0, 32'h0000_0011, 1'b0, 4'd4},  // R4 zeros keep
    '{1'b0, 5'd0,  1'b1, 2'd0, 32'h0000_0000, 2'd0, 32'h0000_0011, 1'b0, 4'd10}, // R10 pend write ignored
    '{1'b0, 5'd0,  1'b1, 2'd1, 32'h0000_0000, 2'd1, 32'h0000_0000, 1'b0, 4'd5},  // R5 mask to zero re-arms
    '{1'b0, 5'd0,  1'b1, 2'd1, 32'h0000_0010, 2'd1, 32'h0000_0010, 1'b1, 4'd3}   // R3 enable raises pulse
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_idle();
    cmpl_valid = 1'b0; cmpl_code = '0; reg_wr_en = 1'b0;
    reg_addr = '0; reg_wdata = '0; rd_addr = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    drive_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    drive_idle();
    do_reset();

    // R8 reset state
    rd_addr = 2'd0; #1 chk("R8 pend after reset", rd_data, 32'h0);
    rd_addr = 2'd1; #1 chk("R8 enable after reset", rd_data, 32'h0);
    chk("R8 irq after reset", {31'b0, irq_pulse}, 32'h0);
    rd_addr = 2'd3; #1 chk("R10 reserved reads 0", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      cmpl_valid = VECS[i].cv;  cmpl_code = VECS[i].code;
      reg_wr_en  = VECS[i].we;  reg_addr  = VECS[i].wa;
      reg_wdata  = VECS[i].wd;  rd_addr   = VECS[i].ra;
      step();
      drive_idle();
      rd_addr = VECS[i].ra;
      #1;
      chk($sformatf("R%0d vec %0d rd_data", VECS[i].req, i), rd_data, VECS[i].erd);
      chk($sformatf("R%0d vec %0d irq", VECS[i].req, i), {31'b0, irq_pulse}, {31'b0, VECS[i].eirq});
    end

    // R2 pulse gone after vector walk
    step(); chk("R2 pulse ends", {31'b0, irq_pulse}, 32'h0);

    // R10 repeated read no side effect
    rd_addr = 2'd0; #1 chk("R10 read 1", rd_data, 32'h0000_0011);
    step(); chk("R10 read 2", rd_data, 32'h0000_0011);

    // R8 mid-run reset: armed afterwards
    do_reset();
    rd_addr = 2'd0; #1 chk("R8 pend cleared by reset", rd_data, 32'h0);
    reg_wr_en = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0000_0004;
    step(); drive_idle();
    cmpl_valid = 1'b1; cmpl_code = 5'd2;
    step(); drive_idle();
    #1 chk("R8 armed after reset", {31'b0, irq_pulse}, 32'h1);

    // R1 every code sets its bit with all enabled, then drain
    reg_wr_en = 1'b1; reg_addr = 2'd1; reg_wdata = 32'hFFFF_FFFF;
    step(); drive_idle();
    for (int c = 0; c < 32; c++) begin
      cmpl_valid = 1'b1; cmpl_code = 5'(c);
      step();
    end
    drive_idle(); rd_addr = 2'd0;
    #1 chk("R1 all codes set", rd_data, 32'hFFFF_FFFF);
    chk("R5 no pulse while held", {31'b0, irq_pulse}, 32'h0);
    reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = 32'hFFFF_FFFF;
    step(); drive_idle();
    rd_addr = 2'd0; #1 chk("R4 full clear", rd_data, 32'h0);
    cmpl_valid = 1'b1; cmpl_code = 5'd9;
    step(); drive_idle();
    #1 chk("R9 pulse after drain", {31'b0, irq_pulse}, 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule